// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Collector

This block gathers single-cycle fault and event pulses from many sources into one status word, with one bit for each source. A per-bit mask decides which pending bits may pull the shared interrupt line low. The line is shown as an output enable: when the enable is high the pad drives 0, and when it is low the pad floats.

A host reads the status word through a read strobe. The cycle after the strobe, the block presents the word as it stood before the read. In the same edge it clears every bit and lets the line go. A source whose fault is still present keeps its level input high. A free-running re-check timer sets that bit again on each of its ticks, so a lasting fault cannot stay hidden after a read. The tick period is a parameter in clock cycles. It must be chosen no longer than 32 µs at the clock in use. The host can also write the mask and read it back.

Top module: `intr_r2c_top`

## Requirements
- R1: A one-cycle pulse on `evt_pulse[i]` sets status bit i at the next clock edge. The bit holds until a status read clears it.
- R2: `irq_oe` is 1 exactly when at least one status bit is 1 and its mask bit is 0. A mask bit of 1 means that source is masked. A masked bit that becomes unmasked raises `irq_oe`.
- R3: A `stat_rd` strobe produces `stat_rvalid` = 1 for one cycle on the next cycle. In that cycle `stat_rdata` holds the status word from the strobe cycle, taken before the clear.
- R4: A status read clears all status bits at the same edge. `irq_oe` falls in the cycle after the strobe unless some bit is set again.
- R5: An event pulse in the same cycle as a status read wins over the clear, and its bit is 1 after the read.
- R6: The re-check timer ticks at least once every `RECHECK_CYC` cycles. On a tick, every bit whose `flt_level` input is high is set again. A fault held through a read is therefore pending again within `RECHECK_CYC` cycles.
- R7: `mask_wr` loads `mask_wdata` into the mask at the next edge, and `mask_rdata` shows it. Masking does not stop a status bit from being set.
- R8: After reset the status word and the mask are all zero, and `irq_oe` and `stat_rvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | SRC_NUM | One-cycle event or fault pulses, one per source |
| flt_level | input | SRC_NUM | High while a source's fault condition persists |
| stat_rd | input | 1 | Status read strobe (read and clear) |
| stat_rdata | output | SRC_NUM | Status word captured by the last read |
| stat_rvalid | output | 1 | High for one cycle when `stat_rdata` is fresh |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | SRC_NUM | New mask value, 1 = masked |
| mask_rdata | output | SRC_NUM | Current mask |
| irq_oe | output | 1 | Interrupt pad enable: 1 drives the line low |

## Verification
The assertions assume that `evt_pulse` is a single-cycle pulse for each occurrence. They also assume that `flt_level` is only meaningful at re-check ticks, and that a mask write does not land in the cycle used to judge the interrupt line. The stimulus drives every input on the falling edge and lowers pulses after one cycle. It keeps mask writes apart from the cycles where interrupt assertion is checked. For the persistent-fault case, the bench only bounds the delay against the tick period and does not predict the exact tick.

// File: rtl/intr_r2c_pkg.sv
package intr_r2c_pkg;

    localparam int unsigned DEF_SRC_NUM    = 8;
    localparam int unsigned DEF_CLK_MHZ    = 200;
    localparam int unsigned MAX_RECHECK_US = 32;

    // Longest re-check period, in cycles, that stays within the bound
    function automatic int unsigned recheck_limit(input int unsigned clk_mhz);
        return clk_mhz * MAX_RECHECK_US;
    endfunction

endpackage

// File: rtl/intr_r2c_timer.sv
module intr_r2c_timer #(
    parameter int unsigned PERIOD = 6400
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = (tmr_q.cnt == LAST);
        if (tick) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/intr_r2c_cell.sv
module intr_r2c_cell (
    input  logic stat_q,
    input  logic evt,
    input  logic lvl,
    input  logic tick,
    input  logic clr,
    input  logic mask_n,
    output logic stat_n,
    output logic pend_n
);
    always_comb begin
        // A new event or a re-check hit overrides the read clear
        stat_n = (stat_q & ~clr) | evt | (lvl & tick);
        pend_n = stat_n & ~mask_n;
    end
endmodule

// File: rtl/intr_r2c_top.sv
module intr_r2c_top #(
    parameter int unsigned SRC_NUM     = intr_r2c_pkg::DEF_SRC_NUM,
    parameter int unsigned RECHECK_CYC = intr_r2c_pkg::recheck_limit(intr_r2c_pkg::DEF_CLK_MHZ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_NUM-1:0] evt_pulse,
    input  logic [SRC_NUM-1:0] flt_level,
    input  logic               stat_rd,
    output logic [SRC_NUM-1:0] stat_rdata,
    output logic               stat_rvalid,
    input  logic               mask_wr,
    input  logic [SRC_NUM-1:0] mask_wdata,
    output logic [SRC_NUM-1:0] mask_rdata,
    output logic               irq_oe
);
    typedef struct packed {
        logic [SRC_NUM-1:0] stat;
        logic [SRC_NUM-1:0] mask;
        logic [SRC_NUM-1:0] rdata;
        logic               rvalid;
        logic               irq;
    } regs_t;

    regs_t regs_d, regs_q;

    logic               recheck_tick;
    logic [SRC_NUM-1:0] mask_nxt;
    logic [SRC_NUM-1:0] stat_nxt;
    logic [SRC_NUM-1:0] pend_nxt;
    logic [SRC_NUM-1:0] stat_now;

    intr_r2c_timer #(
        .PERIOD (RECHECK_CYC)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (recheck_tick)
    );

    assign mask_nxt = mask_wr ? mask_wdata : regs_q.mask;

    for (genvar gi = 0; gi < SRC_NUM; gi++) begin : g_bit
        intr_r2c_cell cell_i (
            .stat_q (regs_q.stat[gi]),
            .evt    (evt_pulse[gi]),
            .lvl    (flt_level[gi]),
            .tick   (recheck_tick),
            .clr    (stat_rd),
            .mask_n (mask_nxt[gi]),
            .stat_n (stat_nxt[gi]),
            .pend_n (pend_nxt[gi])
        );
    end

    always_comb begin
        regs_d        = regs_q;
        regs_d.stat   = stat_nxt;
        regs_d.mask   = mask_nxt;
        regs_d.rvalid = stat_rd;
        if (stat_rd) begin
            regs_d.rdata = regs_q.stat;
        end
        regs_d.irq = |pend_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign stat_now    = regs_q.stat;
    assign stat_rdata  = regs_q.rdata;
    assign stat_rvalid = regs_q.rvalid;
    assign mask_rdata  = regs_q.mask;
    assign irq_oe      = regs_q.irq;
endmodule

// File: rtl/intr_r2c_chk.sv
module intr_r2c_chk #(
    parameter int unsigned SRC_NUM     = 8,
    parameter int unsigned RECHECK_CYC = 6400
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SRC_NUM-1:0] evt_pulse,
    input logic [SRC_NUM-1:0] flt_level,
    input logic               stat_rd,
    input logic [SRC_NUM-1:0] stat_rdata,
    input logic               stat_rvalid,
    input logic               mask_wr,
    input logic [SRC_NUM-1:0] mask_wdata,
    input logic [SRC_NUM-1:0] mask_rdata,
    input logic               irq_oe,
    input logic               tick,
    input logic [SRC_NUM-1:0] stat_q
);
    int unsigned gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= 0;
        end else if (tick) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

    assert_evt_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_pulse & ~mask_rdata)) && !mask_wr) |=> irq_oe);

    assert_quiet_when_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~mask_rdata) == '0) |-> !irq_oe);

    assert_read_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (stat_rvalid && (stat_rdata == $past(stat_q))));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (evt_pulse == '0) && !tick) |=> ((stat_q == '0) && !irq_oe));

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (evt_pulse != '0)) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

    assert_recheck_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((stat_q & $past(flt_level)) == $past(flt_level)));

    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < RECHECK_CYC);

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_rdata == $past(mask_wdata)));
endmodule

bind intr_r2c_top intr_r2c_chk #(
    .SRC_NUM     (SRC_NUM),
    .RECHECK_CYC (RECHECK_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse   (evt_pulse),
    .flt_level   (flt_level),
    .stat_rd     (stat_rd),
    .stat_rdata  (stat_rdata),
    .stat_rvalid (stat_rvalid),
    .mask_wr     (mask_wr),
    .mask_wdata  (mask_wdata),
    .mask_rdata  (mask_rdata),
    .irq_oe      (irq_oe),
    .tick        (recheck_tick),
    .stat_q      (stat_now)
);

// File: tb/intr_r2c_top_tb_top.sv
`timescale 1ns/1ps
module intr_r2c_top_tb_top;
    localparam int unsigned NB = 8;
    localparam int unsigned P  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] evt_pulse = '0;
    logic [NB-1:0] flt_level = '0;
    logic          stat_rd = 1'b0;
    logic [NB-1:0] stat_rdata;
    logic          stat_rvalid;
    logic          mask_wr = 1'b0;
    logic [NB-1:0] mask_wdata = '0;
    logic [NB-1:0] mask_rdata;
    logic          irq_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [NB-1:0] exp_q [$];
    string         tag_q [$];

    always #2.5 clk = ~clk;

    intr_r2c_top #(
        .SRC_NUM     (NB),
        .RECHECK_CYC (P)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_pulse   (evt_pulse),
        .flt_level   (flt_level),
        .stat_rd     (stat_rd),
        .stat_rdata  (stat_rdata),
        .stat_rvalid (stat_rvalid),
        .mask_wr     (mask_wr),
        .mask_wdata  (mask_wdata),
        .mask_rdata  (mask_rdata),
        .irq_oe      (irq_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every read result is matched against the queue
    always @(negedge clk) begin
        if (rst_n && stat_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected rvalid", 32'(stat_rdata), 32'h0);
            end else begin
                logic [NB-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(stat_rdata == e, t, 32'(stat_rdata), 32'(e));
            end
        end
    end

    task automatic pulse_evt(input logic [NB-1:0] bits);
        @(negedge clk);
        evt_pulse = bits;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic do_read(input logic [NB-1:0] exp, input string tag, input logic [NB-1:0] evt_same = '0);
        @(negedge clk);
        stat_rd   = 1'b1;
        evt_pulse = evt_same;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        stat_rd   = 1'b0;
        evt_pulse = '0;
    endtask

    task automatic write_mask(input logic [NB-1:0] m);
        @(negedge clk);
        mask_wr    = 1'b1;
        mask_wdata = m;
        @(negedge clk);
        mask_wr    = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            check(1'b0, "watchdog", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        check(irq_oe == 1'b0, "R8 irq after reset", 32'(irq_oe), 32'h0);
        check(mask_rdata == '0, "R8 mask after reset", 32'(mask_rdata), 32'h0);
        check(stat_rvalid == 1'b0, "R8 rvalid after reset", 32'(stat_rvalid), 32'h0);
        do_read(8'h00, "R8 status after reset");

        // R1 / R2: events set bits and raise the line
        pulse_evt(8'h04);
        check(irq_oe == 1'b1, "R1 irq after event", 32'(irq_oe), 32'h1);
        pulse_evt(8'h10);
        do_read(8'h14, "R3 read returns pre-clear word");
        check(irq_oe == 1'b0, "R4 irq released after read", 32'(irq_oe), 32'h0);
        do_read(8'h00, "R4 status cleared by read");

        // R5: event coincident with a read survives
        pulse_evt(8'h01);
        do_read(8'h01, "R5 read with coincident event", 8'h80);
        check(irq_oe == 1'b1, "R5 irq held by coincident event", 32'(irq_oe), 32'h1);
        do_read(8'h80, "R5 coincident event kept");

        // R7 / R2: masking
        write_mask(8'h0F);
        check(mask_rdata == 8'h0F, "R7 mask readback", 32'(mask_rdata), 32'h0F);
        pulse_evt(8'h02);
        check(irq_oe == 1'b0, "R2 masked bit quiet", 32'(irq_oe), 32'h0);
        do_read(8'h02, "R7 masked bit still captured");
        pulse_evt(8'h20);
        check(irq_oe == 1'b1, "R2 unmasked bit drives line", 32'(irq_oe), 32'h1);
        do_read(8'h20, "R2 unmasked bit read");
        pulse_evt(8'h02);
        check(irq_oe == 1'b0, "R2 masked pending quiet", 32'(irq_oe), 32'h0);
        write_mask(8'h00);
        check(irq_oe == 1'b1, "R2 unmask raises line", 32'(irq_oe), 32'h1);
        do_read(8'h02, "R2 pending bit after unmask");

        // R6: persistent fault is set again within P cycles
        flt_level = 8'h08;
        pulse_evt(8'h08);
        do_read(8'h08, "R6 first read of persistent fault");
        begin
            int seen = -1;
            for (int k = 0; k <= int'(P); k++) begin
                if (irq_oe && seen < 0) seen = k;
                if (seen < 0) @(negedge clk);
            end
            check(seen >= 0, "R6 line pulled again within period", 32'(seen), 32'(P));
        end
        flt_level = 8'h00;
        do_read(8'h08, "R6 bit set again by re-check");

        // R4: cleared fault without level stays released across ticks
        begin
            int bad = 0;
            for (int k = 0; k < int'(3 * P); k++) begin
                @(negedge clk);
                if (irq_oe) bad++;
            end
            check(bad == 0, "R4 stays released without fault", 32'(bad), 32'h0);
        end
        do_read(8'h00, "R4 no spurious bits");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 every read answered", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule